// File: doc/BRIEF.md
# Extended Address CSR Width Modulator

This block holds one capability-extended address CSR whose address field follows the active register width of its privilege level. Software writes a full-width address with a tag and a sealed flag. An external checker supplies one extra bit with each write. That bit says whether the value would still be representable if the address were cut down to the narrow width. The block stores this bit with the CSR.

A single mode input selects the governing width: 1 means 64 bits and 0 means 32 bits. When the mode drops from wide to narrow, the block keeps only the low 32 bits of the stored address and zero-extends them to 64 bits. It never sign-extends them. In the same update it decides whether the tag survives. The tag is lost if the stored representability bit is clear. It is also lost if the value is sealed and the narrowing changed the address. The read port always shows the committed register, so no partial result is ever visible.

Top module: `ecsr_width_mod`

## Requirements
- R1: After reset the read port returns address 0, tag 0 and sealed 0.
- R2: A write (`wr_en_i`=1) with no wide-to-narrow mode change stores the address, tag and sealed flag unchanged, whatever the mode. The stored value is visible on the read port one cycle later.
- R3: When `mode_wide_i` goes from 1 (64-bit) to 0 (32-bit), the next read shows address bits 31:0 unchanged and bits 63:32 zero. Bit 31 is not copied upward.
- R4: On a wide-to-narrow change, the tag reads 0 afterwards if the `wr_repr_narrow_i` bit captured at the last write was 0.
- R5: On a wide-to-narrow change of a sealed value whose address bits 63:32 were nonzero, the tag reads 0 afterwards. A sealed value with zero upper bits keeps its tag. An unsealed value with nonzero upper bits and a captured representability bit of 1 keeps its tag.
- R6: A narrow-to-wide change (`mode_wide_i` 0 to 1) leaves the address and tag unchanged.
- R7: A write in the same cycle as a wide-to-narrow change is applied first. The narrowing then acts on the newly written value, using the `wr_repr_narrow_i` bit of that write.
- R8: With no write and no wide-to-narrow change, the address, tag and sealed flag hold their values. Narrowing never alters the sealed flag, and the tag never becomes 1 without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_wide_i | input | 1 | Governing width: 1 = 64-bit, 0 = 32-bit |
| wr_en_i | input | 1 | CSR write strobe |
| wr_addr_i | input | 64 | Address to write |
| wr_tag_i | input | 1 | Tag to write |
| wr_sealed_i | input | 1 | Sealed flag to write |
| wr_repr_narrow_i | input | 1 | Checker result: value stays representable after narrowing |
| rd_addr_o | output | 64 | Stored address |
| rd_tag_o | output | 1 | Stored tag |
| rd_sealed_o | output | 1 | Stored sealed flag |

## Verification
The assertions take `wr_repr_narrow_i` as correct for the value written with it. They treat `mode_wide_i` as a level that can change in any cycle, including cycles that carry a write. The properties only relate the mode edge to the register contents one cycle later. The stimulus holds each input stable for a full cycle, changes inputs only on the falling edge, and drives a representability bit for every write. It covers both edge directions, and both directions combined with a write.

// File: rtl/ecsr_wm_pkg.sv
package ecsr_wm_pkg;
  localparam int unsigned CSR_XLEN_MAX = 64;

  typedef struct packed {
    logic [CSR_XLEN_MAX-1:0] addr;
    logic                    tag;
    logic                    sealed;
    logic                    repr_narrow;  // precomputed at write time
  } csr_val_t;
endpackage

// File: rtl/ecsr_xlen_track.sv
module ecsr_xlen_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_wide_i,
  output logic narrow_o,
  output logic widen_o
);
  logic prev_wide_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_wide_q <= 1'b1;
    else         prev_wide_q <= mode_wide_i;
  end

  assign narrow_o = prev_wide_q & ~mode_wide_i;
  assign widen_o  = ~prev_wide_q & mode_wide_i;
endmodule

// File: rtl/ecsr_width_narrow.sv
module ecsr_width_narrow
  import ecsr_wm_pkg::*;
#(
  parameter int unsigned XLEN_NARROW = 32
) (
  input  csr_val_t val_i,
  output csr_val_t val_o,
  output logic     addr_changed_o
);
  localparam int unsigned XLEN_MAX = CSR_XLEN_MAX;

  generate
    if (XLEN_NARROW >= XLEN_MAX) begin : g_pass
      assign addr_changed_o = 1'b0;
      assign val_o          = val_i;
    end else begin : g_trunc
      localparam int unsigned HI_W = XLEN_MAX - XLEN_NARROW;
      logic [HI_W-1:0] hi_bits;
      assign hi_bits        = val_i.addr[XLEN_MAX-1:XLEN_NARROW];
      assign addr_changed_o = |hi_bits;
      always_comb begin
        val_o      = val_i;
        val_o.addr = {{HI_W{1'b0}}, val_i.addr[XLEN_NARROW-1:0]};
        // tag survives only if representable and sealed values are not moved
        val_o.tag  = val_i.tag & val_i.repr_narrow &
                     ~(val_i.sealed & addr_changed_o);
      end
    end
  endgenerate
endmodule

// File: rtl/ecsr_width_mod.sv
module ecsr_width_mod
  import ecsr_wm_pkg::*;
#(
  parameter int unsigned XLEN_NARROW = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    mode_wide_i,
  input  logic                    wr_en_i,
  input  logic [CSR_XLEN_MAX-1:0] wr_addr_i,
  input  logic                    wr_tag_i,
  input  logic                    wr_sealed_i,
  input  logic                    wr_repr_narrow_i,
  output logic [CSR_XLEN_MAX-1:0] rd_addr_o,
  output logic                    rd_tag_o,
  output logic                    rd_sealed_o
);
  localparam int unsigned XLEN_MAX = CSR_XLEN_MAX;
  localparam int unsigned HI_W     = XLEN_MAX - XLEN_NARROW;

  csr_val_t csr_q, cur_val, mod_val, nxt_val;
  logic     narrow_evt, widen_evt, addr_changed;

  ecsr_xlen_track u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_wide_i(mode_wide_i),
    .narrow_o   (narrow_evt),
    .widen_o    (widen_evt)
  );

  // write first, then modulate the resulting value
  always_comb begin
    cur_val = csr_q;
    if (wr_en_i) begin
      cur_val.addr        = wr_addr_i;
      cur_val.tag         = wr_tag_i;
      cur_val.sealed      = wr_sealed_i;
      cur_val.repr_narrow = wr_repr_narrow_i;
    end
  end

  ecsr_width_narrow #(.XLEN_NARROW(XLEN_NARROW)) u_narrow (
    .val_i         (cur_val),
    .val_o         (mod_val),
    .addr_changed_o(addr_changed)
  );

  assign nxt_val = narrow_evt ? mod_val : cur_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) csr_q <= '{addr: '0, tag: 1'b0, sealed: 1'b0, repr_narrow: 1'b1};
    else         csr_q <= nxt_val;
  end

  assign rd_addr_o   = csr_q.addr;
  assign rd_tag_o    = csr_q.tag;
  assign rd_sealed_o = csr_q.sealed;

  p_zext_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    narrow_evt |=> (rd_addr_o[XLEN_MAX-1:XLEN_MAX-HI_W] == '0));

  p_low_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    narrow_evt |=> (rd_addr_o[XLEN_NARROW-1:0] == $past(cur_val.addr[XLEN_NARROW-1:0])));

  p_repr_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (narrow_evt && !cur_val.repr_narrow) |=> !rd_tag_o);

  p_sealed_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (narrow_evt && cur_val.sealed && addr_changed) |=> !rd_tag_o);

  p_widen_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (widen_evt && !wr_en_i) |=> ($stable(rd_addr_o) && $stable(rd_tag_o)));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !narrow_evt) |=> ($stable(rd_addr_o) && $stable(rd_tag_o) && $stable(rd_sealed_o)));

  p_no_tag_gain_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !$rose(rd_tag_o));
endmodule

// File: tb/ecsr_width_mod_tb_top.sv
module ecsr_width_mod_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_wide_i = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [63:0] wr_addr_i = '0;
  logic        wr_tag_i = 1'b0, wr_sealed_i = 1'b0, wr_repr_narrow_i = 1'b0;
  logic [63:0] rd_addr_o;
  logic        rd_tag_o, rd_sealed_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  ecsr_width_mod dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_wide_i(mode_wide_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_tag_i(wr_tag_i),
    .wr_sealed_i(wr_sealed_i), .wr_repr_narrow_i(wr_repr_narrow_i),
    .rd_addr_o(rd_addr_o), .rd_tag_o(rd_tag_o), .rd_sealed_o(rd_sealed_o)
  );

  typedef struct {
    logic [63:0] addr;
    logic        tag;
    logic        sealed;
    string       req;
  } exp_t;

  exp_t q[$];
  int   checks = 0, failures = 0, cycles = 0;
  bit   done = 0;

  // reference model state
  logic [63:0] m_addr = '0;
  logic        m_tag = 0, m_sealed = 0, m_repr = 1, m_prev_wide = 1;

  task automatic compare(input exp_t e);
    checks++;
    if (rd_addr_o !== e.addr || rd_tag_o !== e.tag || rd_sealed_o !== e.sealed) begin
      failures++;
      $display("FAIL %s: addr=%h tag=%b sealed=%b expected addr=%h tag=%b sealed=%b",
               e.req, rd_addr_o, rd_tag_o, rd_sealed_o, e.addr, e.tag, e.sealed);
    end
  endtask

  task automatic step(input logic mode, input logic we, input logic [63:0] a,
                      input logic t, input logic s, input logic r, input string req);
    exp_t e;
    @(negedge clk_i);
    mode_wide_i = mode; wr_en_i = we; wr_addr_i = a;
    wr_tag_i = t; wr_sealed_i = s; wr_repr_narrow_i = r;
    if (we) begin m_addr = a; m_tag = t; m_sealed = s; m_repr = r; end
    if (m_prev_wide && !mode) begin
      m_tag  = m_tag & m_repr & ~(m_sealed & (m_addr[63:32] != 0));
      m_addr = {32'h0, m_addr[31:0]};
    end
    m_prev_wide = mode;
    e.addr = m_addr; e.tag = m_tag; e.sealed = m_sealed; e.req = req;
    q.push_back(e);
  endtask

  // monitor: compare after each rising edge
  always @(posedge clk_i) begin
    #2;
    if (rst_ni && q.size() > 0) compare(q.pop_front());
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    exp_t e;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    e.addr = '0; e.tag = 0; e.sealed = 0; e.req = "R1 reset";
    compare(e);

    // R2 plain writes in both modes
    step(1, 1, 64'h1234_5678_9abc_def0, 1, 0, 1, "R2 write wide");
    step(1, 0, '0, 0, 0, 0, "R8 hold");
    // R3 narrowing, low half with bit31 set, no sign extension
    step(1, 1, 64'hFFFF_FFFF_8000_1234, 1, 0, 1, "R2 write");
    step(0, 0, '0, 0, 0, 0, "R3 zero-extend");
    step(0, 0, '0, 0, 0, 0, "R8 hold narrow");
    // R6 widening
    step(1, 0, '0, 0, 0, 0, "R6 widen keeps");
    // R4 unrepresentable
    step(1, 1, 64'h0000_0000_0000_0040, 1, 0, 0, "R2 write");
    step(0, 0, '0, 0, 0, 0, "R4 repr lost");
    // R2 write while narrow, full value kept
    step(0, 1, 64'hAAAA_0000_0000_0001, 1, 1, 1, "R2 write narrow");
    step(1, 0, '0, 0, 0, 0, "R6 widen sealed");
    // R5 sealed with nonzero upper
    step(0, 0, '0, 0, 0, 0, "R5 sealed moved");
    // R5 sealed with zero upper keeps tag
    step(1, 1, 64'h0000_0000_CAFE_0000, 1, 1, 1, "R2 write");
    step(0, 0, '0, 0, 0, 0, "R5 sealed unmoved");
    // R5 unsealed with upper nonzero keeps tag
    step(1, 1, 64'h0F00_0000_0000_7777, 1, 0, 1, "R2 write");
    step(0, 0, '0, 0, 0, 0, "R5 unsealed moved");
    // R7 write during narrowing
    step(1, 0, '0, 0, 0, 0, "R6 widen");
    step(0, 1, 64'h5555_0000_8888_0000, 1, 1, 1, "R7 write+narrow sealed");
    step(1, 1, 64'h0000_0001_0000_0002, 1, 0, 0, "R7 setup stale flag");
    step(0, 1, 64'h0000_0001_0000_0003, 1, 0, 1, "R7 uses new repr");
    // R8 no tag gain without write
    step(1, 0, '0, 0, 0, 0, "R8 no tag gain");
    step(0, 0, '0, 0, 0, 0, "R8 narrow again");
    step(0, 0, '0, 0, 0, 0, "R8 hold");
    @(negedge clk_i);
    @(negedge clk_i);
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule